// File: doc/BRIEF.md
# ADC Power and Conversion Sequencer

This block is the control core of a low-power 8-bit sampling converter that switches itself off between samples. It watches a single convert-start line. A rising edge while the converter is off wakes it and starts an internal power-up timer. A falling edge starts a conversion. If the line falls before power-up has finished, the conversion waits and then begins by itself the moment the timer expires.

A conversion runs for a fixed number of system-clock cycles. At its end, the sample presented by a behavioural stand-in for the analog core is captured into a holding register, and a one-cycle done strobe is raised. If convert-start is still low at that point, the block drops straight back to the powered-down state.

Both intervals are derived from a cycles-per-microsecond parameter. Power-up is 1.5 µs and conversion is 5 µs, each rounded up to whole clock cycles. The convert-start line is asynchronous and passes through a two-flop synchroniser before its edges are detected.

Top module: `adcPowerSequencer`

## Requirements
- R1: While reset is asserted, and immediately after it, `powerEn`, `busy` and `resultValid` are 0 and `result` is 0.
- R2: A rising edge on `convStart` while powered down raises both `powerEn` and `busy` on the third clock edge after the input changes (two synchroniser stages plus the state register).
- R3: Power-up lasts WAKE_CYC = ceil(CLK_PER_US*15/10) cycles. If `convStart` fell before the synchronised level is sampled at the last power-up cycle, the conversion starts right at the end of power-up with no further edge needed.
- R4: If `convStart` is still high when power-up ends, the block waits powered and idle (`powerEn`=1, `busy`=0). A later falling edge starts a conversion on the third clock edge after the input changes.
- R5: A conversion lasts CONV_CYC = ceil(CLK_PER_US*50/10) cycles. On its final edge `sampleIn` is copied into `result`, and `resultValid` is high for exactly one cycle, during which `busy` is 0.
- R6: `result` keeps its previous value at all other times, including during power-up, during conversion and while powered down.
- R7: If synchronised `convStart` is low when a conversion completes, `powerEn` falls on the same edge that raises `resultValid`.
- R8: If synchronised `convStart` is high when a conversion completes, the block stays powered and idle. The next falling edge starts a conversion without any new power-up interval.
- R9: Edges on `convStart` during a conversion are ignored: the conversion is neither restarted nor extended, and no extra result is produced.
- R10: `busy` is never high while `powerEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | Asynchronous convert-start line: rising edge wakes, falling edge converts |
| sampleIn | input | DATA_W | Value supplied by the behavioural analog stand-in |
| powerEn | output | 1 | High while the converter core is powered |
| busy | output | 1 | High during power-up and conversion |
| resultValid | output | 1 | One-cycle strobe when `result` is updated |
| result | output | DATA_W | Most recent conversion result |

## Verification
On every cycle, the assertions check the relationships among the flags: `busy` implies power, the done strobe is a single cycle and never coincides with `busy`, `result` only moves with the strobe, and every power-up begins busy. The bench scenarios are needed for the timing itself. They confirm that done lands exactly WAKE_CYC+CONV_CYC cycles after a short pulse, that a falling edge is deferred exactly up to the end of the power-up timer, and that a late fall is taken from the ready state. They also cover whether the block powers down or stays up depending on the line level at the end, and that edges during a conversion produce no extra result.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAKE  = 2'd1,
    ST_READY = 2'd2,
    ST_CONV  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWake;
    logic loadConv;
    logic latch;
  } seqStrobe_t;

endpackage

// File: rtl/adcSyncEdge.sv
module adcSyncEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prevLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain   <= '0;
      prevLvl <= 1'b0;
    end else begin
      chain   <= {chain[STAGES-2:0], din};
      prevLvl <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prevLvl;
  assign fall = ~lvl & prevLvl;

endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lvl,
  input  logic       rise,
  input  logic       fall,
  input  logic       timerZero,
  output seqStrobe_t strobe,
  output logic       powerEn,
  output logic       busy
);

  seqState_t state, nextState;
  logic      pendingFall;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_OFF: begin
        if (rise) begin
          nextState       = ST_WAKE;
          strobe.loadWake = 1'b1;
        end
      end
      ST_WAKE: begin
        if (timerZero) begin
          if (pendingFall || !lvl) begin
            nextState       = ST_CONV;
            strobe.loadConv = 1'b1;
          end else begin
            nextState = ST_READY;
          end
        end
      end
      ST_READY: begin
        if (fall) begin
          nextState       = ST_CONV;
          strobe.loadConv = 1'b1;
        end
      end
      ST_CONV: begin
        if (timerZero) begin
          strobe.latch = 1'b1;
          nextState    = lvl ? ST_READY : ST_OFF;
        end
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_OFF;
      pendingFall <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_WAKE && !timerZero)
        pendingFall <= pendingFall | fall;
      else
        pendingFall <= 1'b0;
    end
  end

  assign powerEn = (state != ST_OFF);
  assign busy    = (state == ST_WAKE) || (state == ST_CONV);

endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAKE_CYC = 12,
  parameter int CONV_CYC = 40,
  parameter int TMR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              timerZero,
  output logic              resultValid,
  output logic [DATA_W-1:0] result
);

  logic [TMR_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer       <= '0;
      resultValid <= 1'b0;
      result      <= '0;
    end else begin
      if (strobe.loadWake)
        timer <= TMR_W'(WAKE_CYC - 1);
      else if (strobe.loadConv)
        timer <= TMR_W'(CONV_CYC - 1);
      else if (timer != '0)
        timer <= timer - 1'b1;

      resultValid <= strobe.latch;
      if (strobe.latch)
        result <= sampleIn;
    end
  end

  assign timerZero = (timer == '0);

endmodule

// File: rtl/adcPowerSequencer.sv
module adcPowerSequencer
  import adcSeqPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_PER_US  = 8,
  parameter int WAKE_TENTHS = 15,
  parameter int CONV_TENTHS = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              powerEn,
  output logic              busy,
  output logic              resultValid,
  output logic [DATA_W-1:0] result
);

  localparam int WAKE_CYC = (CLK_PER_US * WAKE_TENTHS + 9) / 10;
  localparam int CONV_CYC = (CLK_PER_US * CONV_TENTHS + 9) / 10;
  localparam int MAX_CYC  = (WAKE_CYC > CONV_CYC) ? WAKE_CYC : CONV_CYC;
  localparam int TMR_W    = $clog2(MAX_CYC + 1);

  logic       lvl, rise, fall, timerZero;
  seqStrobe_t strobe;

  adcSyncEdge #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (convStart),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  adcSeqCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lvl       (lvl),
    .rise      (rise),
    .fall      (fall),
    .timerZero (timerZero),
    .strobe    (strobe),
    .powerEn   (powerEn),
    .busy      (busy)
  );

  adcSeqData #(
    .DATA_W   (DATA_W),
    .WAKE_CYC (WAKE_CYC),
    .CONV_CYC (CONV_CYC),
    .TMR_W    (TMR_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sampleIn    (sampleIn),
    .timerZero   (timerZero),
    .resultValid (resultValid),
    .result      (result)
  );

endmodule

// File: rtl/adcSeqChecker.sv
module adcSeqChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              powerEn,
  input logic              busy,
  input logic              resultValid,
  input logic [DATA_W-1:0] result
);

  assert_busy_powered_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> powerEn);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !busy);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> resultValid);

  assert_wake_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerEn) |-> busy);

endmodule

bind adcPowerSequencer adcSeqChecker #(.DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .powerEn     (powerEn),
  .busy        (busy),
  .resultValid (resultValid),
  .result      (result)
);

// File: tb/adcPowerSequencer_test.sv
module adcPowerSequencer_test;

  localparam int CPU  = 8;
  localparam int WAKE = (CPU * 15 + 9) / 10;
  localparam int CONV = (CPU * 50 + 9) / 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convStart = 1'b0;
  logic [7:0] sampleIn = 8'h00;
  logic       powerEn, busy, resultValid;
  logic [7:0] result;

  adcPowerSequencer #(.DATA_W(8), .CLK_PER_US(CPU)) uut (
    .clk(clk), .rstN(rstN), .convStart(convStart), .sampleIn(sampleIn),
    .powerEn(powerEn), .busy(busy), .resultValid(resultValid), .result(result)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nCmp = 0;
  int nBad = 0;

  typedef struct {
    int         when;
    logic [7:0] val;
    logic       pwr;
  } expItem_t;
  expItem_t sbq[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    nCmp++;
    if (act !== expv) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // push expectation for a pulse that starts from the powered-down state
  task automatic pulseFromOff(input logic [7:0] v, input int hi);
    int c, f, st;
    c = cyc;
    sampleIn = v;
    convStart = 1'b1;
    tick(hi);
    convStart = 1'b0;
    f = cyc;
    st = (c + 3 + WAKE > f + 3) ? c + 3 + WAKE : f + 3;
    sbq.push_back('{st + CONV, v, 1'b0});
  endtask

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    expItem_t e;
    if (rstN && resultValid) begin
      if (sbq.size() == 0) begin
        check("R9 unexpected result", 1, 0);
      end else begin
        e = sbq.pop_front();
        check("R5 done cycle", cyc, e.when);
        check("R5 latched value", result, e.val);
        check("R7/R8 power after done", powerEn, e.pwr);
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c, f, d;
    // R1 reset
    tick(3);
    check("R1 powerEn in reset", powerEn, 0);
    check("R1 busy in reset", busy, 0);
    rstN = 1'b1;
    tick(2);
    check("R1 powerEn after reset", powerEn, 0);
    check("R1 resultValid after reset", resultValid, 0);
    check("R1 result after reset", result, 0);

    // short pulse, fall during power-up (R2, R3, R6, R7)
    c = cyc;
    sampleIn = 8'hA5;
    convStart = 1'b1;
    tick(2);
    check("R2 not yet powered", powerEn, 0);
    tick(1);
    check("R2 powerEn on wake", powerEn, 1);
    check("R2 busy on wake", busy, 1);
    convStart = 1'b0;
    sbq.push_back('{c + 3 + WAKE + CONV, 8'hA5, 1'b0});
    tick(WAKE);
    check("R3 converting after deferred fall", busy, 1);
    check("R6 result held during conversion", result, 0);
    tick(CONV + 2);
    check("R7 powered down", powerEn, 0);
    check("R7 idle", busy, 0);

    // long pulse, ready state then fall (R4)
    c = cyc;
    sampleIn = 8'h3C;
    convStart = 1'b1;
    tick(WAKE + 8);
    check("R4 ready powered", powerEn, 1);
    check("R4 ready not busy", busy, 0);
    convStart = 1'b0;
    f = cyc;
    sbq.push_back('{f + 3 + CONV, 8'h3C, 1'b0});
    tick(2);
    check("R4 not yet converting", busy, 0);
    tick(1);
    check("R4 converting", busy, 1);
    check("R6 old result kept", result, 8'hA5);
    tick(CONV + 4);

    // boundaries of the deferral window (R3, R4)
    pulseFromOff(8'h11, WAKE);
    tick(CONV + 10);
    pulseFromOff(8'h22, WAKE + 1);
    tick(CONV + 10);
    pulseFromOff(8'h01, 1);
    tick(WAKE + CONV + 6);

    // line high at end of conversion: stay powered (R8, R9)
    c = cyc;
    sampleIn = 8'h77;
    convStart = 1'b1;
    tick(2);
    convStart = 1'b0;
    d = c + 3 + WAKE + CONV;
    sbq.push_back('{d, 8'h77, 1'b1});
    tick(WAKE + 6);
    convStart = 1'b1;
    tick(d - cyc + 4);
    check("R8 stays powered", powerEn, 1);
    check("R8 idle when powered", busy, 0);
    sampleIn = 8'h99;
    convStart = 1'b0;
    f = cyc;
    sbq.push_back('{f + 3 + CONV, 8'h99, 1'b0});
    tick(3);
    check("R8 conversion without wake", busy, 1);
    tick(CONV + 4);

    // pulse during conversion ignored (R9)
    c = cyc;
    sampleIn = 8'h5A;
    convStart = 1'b1;
    tick(2);
    convStart = 1'b0;
    sbq.push_back('{c + 3 + WAKE + CONV, 8'h5A, 1'b0});
    tick(WAKE + 10);
    convStart = 1'b1;
    tick(3);
    convStart = 1'b0;
    tick(CONV + 20);
    check("R9 no rewake after ignored pulse", powerEn, 0);

    // idle: sample changes have no effect (R6)
    sampleIn = 8'hFF;
    tick(20);
    check("R6 result unchanged while off", result, 8'h5A);
    check("R5 all results seen", sbq.size(), 0);

    summary();
    $finish;
  end

endmodule